// File: doc/BRIEF.md
# Multi-mode 16-bit timer/event counter

This block is a 16-bit up-counter with a preload register and a request flag. A 2-bit mode field selects how the counter advances. It can count edges of an external input, or count ticks of an internal clock enable, or count those ticks only while the external input sits at a chosen level. A single polarity bit picks the edge or the level, and a run bit starts and stops counting.

When the counter steps past its all-ones value, it takes the preload value on that same clock and raises a request flag. The flag stays high until software clears it. In pulse-width mode the counter stops by itself at the end of the measured level, so the count that software reads back is the width of the pulse in ticks.

All registers are reached through a simple write port and a combinational read port. The external input must already be synchronous to `clk_i`.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, preload, control word and request flag all read zero.
- R2: The count holds its value whenever the run bit is 0 or the mode is 00, whatever `ext_i` and `tick_i` do.
- R3: Mode 01 (event count) adds one for each rising edge of `ext_i` when the polarity bit is 0, and for each falling edge when it is 1. `tick_i` has no effect in this mode.
- R4: Mode 10 (timer) adds one on each cycle in which `tick_i` is high. `ext_i` has no effect in this mode.
- R5: Mode 11 (pulse width) adds one on each cycle in which `tick_i` is high and `ext_i` is at the measured level. The measured level is high for polarity 0 and low for polarity 1.
- R6: In mode 11, the edge that ends the measured level clears the run bit, and the count then holds. A write to the control register in that same cycle takes priority over the auto-clear.
- R7: An increment from 16'hFFFF loads the preload value into the count in that same cycle and sets the request flag.
- R8: The request flag stays set until `clr_req_i` is pulsed. If an overflow and a clear happen in the same cycle, the flag is set.
- R9: Writing the preload register while the run bit is 0 also loads the count. While the run bit is 1, the write changes only the preload, and the new value is used at the next wrap.
- R10: The register select for writes and reads is 0 for preload, 1 for control and 2 for count (read only). Select 3 on the read side returns the request flag in bit 0. The control word is {run[3], polarity[2], mode[1:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal count clock enable |
| ext_i | input | 1 | External input, already synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write register select |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 16 | Read data |
| clr_req_i | input | 1 | Clear the request flag |
| req_o | output | 1 | Overflow request flag |

## Verification
The hardest case to reach is an overflow that lands in the same cycle as a clear of the request flag. Reaching it by counting up from zero would take 65536 ticks. Instead, the stimulus stops the counter and writes 16'hFFFF to the preload while stopped, which also loads the count. It then starts timer mode and raises `tick_i` and `clr_req_i` together on one cycle. The pulse-width auto-stop gets the same kind of setup: the bench places a measured pulse with a gap of no tick inside it, then checks that the trailing edge leaves both the count and the run bit frozen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EVT = 2'b01,
    MODE_TMR = 2'b10,
    MODE_PW  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      run;
    logic      pol;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam logic [1:0] SEL_PRE = 2'd0;
  localparam logic [1:0] SEL_CTL = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_REQ = 2'd3;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = inc_i & ~load_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i) begin
      if (cnt_q == CNT_MAX) cnt_q <= reload_val_i;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R7
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && cnt_q == CNT_MAX) |=> (cnt_q == $past(reload_val_i)));
endmodule

// File: rtl/tmr_req_flag.sv
module tmr_req_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (set_i)  req_q <= 1'b1;
    else if (clr_i)  req_q <= 1'b0;
  end

  assign req_o = req_q;

  // R8
  req_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !clr_i) |=> req_q);
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> req_q);
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ext_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             clr_req_i,
  output logic             req_o
);
  localparam int CTL_W = $bits(tmr_ctrl_t);

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt;
  logic             ext_rise, ext_fall;
  logic             inc, ovf, pw_stop;
  logic             wr_pre, wr_ctl, meas_lvl, trail_edge;

  assign wr_pre = wr_en_i && (wr_sel_i == SEL_PRE);
  assign wr_ctl = wr_en_i && (wr_sel_i == SEL_CTL);

  tmr_edge_det i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (ext_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  // polarity 0: rising edge / high level; 1: falling edge / low level
  assign meas_lvl   = ext_i ^ ctrl_q.pol;
  assign trail_edge = ctrl_q.pol ? ext_rise : ext_fall;

  always_comb begin
    inc = 1'b0;
    if (ctrl_q.run) begin
      unique case (ctrl_q.mode)
        MODE_OFF: inc = 1'b0;
        MODE_EVT: inc = ctrl_q.pol ? ext_fall : ext_rise;
        MODE_TMR: inc = tick_i;
        MODE_PW:  inc = tick_i & meas_lvl;
      endcase
    end
  end

  assign pw_stop = ctrl_q.run && (ctrl_q.mode == MODE_PW) && trail_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pre_q  <= '0;
    end else begin
      if (wr_pre)       pre_q <= wr_data_i;
      if (wr_ctl)       ctrl_q <= tmr_ctrl_t'(wr_data_i[CTL_W-1:0]);
      else if (pw_stop) ctrl_q.run <= 1'b0;
    end
  end

  tmr_count_core #(.CNT_W(CNT_W)) i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inc_i        (inc),
    .load_i       (wr_pre && !ctrl_q.run),
    .load_val_i   (wr_data_i),
    .reload_val_i (pre_q),
    .cnt_o        (cnt),
    .ovf_o        (ovf)
  );

  tmr_req_flag i_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf),
    .clr_i  (clr_req_i),
    .req_o  (req_o)
  );

  always_comb begin
    unique case (rd_sel_i)
      SEL_PRE: rd_data_o = pre_q;
      SEL_CTL: rd_data_o = {{(CNT_W-CTL_W){1'b0}}, ctrl_q};
      SEL_CNT: rd_data_o = cnt;
      SEL_REQ: rd_data_o = {{(CNT_W-1){1'b0}}, req_o};
    endcase
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_en_i) |=> $stable(cnt));
  // R3
  evt_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.mode == MODE_EVT && !ext_rise && !ext_fall && !wr_en_i) |=> $stable(cnt));
  // R6
  pw_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw_stop && !wr_ctl) |=> !ctrl_q.run);
endmodule

// File: tb/test_evt_timer16.sv
module test_evt_timer16;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        ext_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_sel_i = 2'd0;
  logic [15:0] rd_data_o;
  logic        clr_req_i = 1'b0;
  logic        req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  evt_timer16 i_evt_timer16 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ext_i(ext_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .clr_req_i(clr_req_i), .req_o(req_o)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  ctl;
    logic        ext;
    logic        tick;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  // ctl = {run, pol, mode}
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'b1001, 1'b0, 1'b0, 16'd0,  4'd3},
    '{1'b0, 4'b0000, 1'b1, 1'b0, 16'd1,  4'd3},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd1,  4'd3},
    '{1'b0, 4'b0000, 1'b0, 1'b1, 16'd1,  4'd3},
    '{1'b0, 4'b0000, 1'b1, 1'b0, 16'd2,  4'd3},
    '{1'b1, 4'b1101, 1'b1, 1'b0, 16'd2,  4'd3},
    '{1'b0, 4'b0000, 1'b0, 1'b0, 16'd3,  4'd3},
    '{1'b0, 4'b0000, 1'b1, 1'b0, 16'd3,  4'd3},
    '{1'b0, 4'b0000, 1'b0, 1'b0, 16'd4,  4'd3},
    '{1'b1, 4'b1010, 1'b0, 1'b0, 16'd4,  4'd4},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd5,  4'd4},
    '{1'b0, 4'b0000, 1'b0, 1'b0, 16'd5,  4'd4},
    '{1'b0, 4'b0000, 1'b0, 1'b1, 16'd6,  4'd4},
    '{1'b1, 4'b0010, 1'b0, 1'b0, 16'd6,  4'd2},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd6,  4'd2},
    '{1'b1, 4'b1000, 1'b0, 1'b0, 16'd6,  4'd2},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd6,  4'd2},
    '{1'b0, 4'b0000, 1'b0, 1'b1, 16'd6,  4'd2},
    '{1'b1, 4'b1011, 1'b0, 1'b0, 16'd6,  4'd5},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd7,  4'd5},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd8,  4'd5},
    '{1'b0, 4'b0000, 1'b1, 1'b0, 16'd8,  4'd5},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd9,  4'd5},
    '{1'b0, 4'b0000, 1'b0, 1'b1, 16'd9,  4'd6},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd9,  4'd6},
    '{1'b1, 4'b1111, 1'b1, 1'b0, 16'd9,  4'd5},
    '{1'b0, 4'b0000, 1'b0, 1'b1, 16'd10, 4'd5},
    '{1'b0, 4'b0000, 1'b0, 1'b1, 16'd11, 4'd5},
    '{1'b0, 4'b0000, 1'b1, 1'b1, 16'd11, 4'd6},
    '{1'b0, 4'b0000, 1'b0, 1'b1, 16'd11, 4'd6}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [1:0] sel, input logic [15:0] exp);
    rd_sel_i = sel;
    #1;
    check(req, rd_data_o, exp);
  endtask

  // drive at negedge, return at the following negedge
  task automatic step(input logic wr, input logic [1:0] sel, input logic [15:0] data,
                      input logic ext, input logic tick, input logic clr);
    wr_en_i = wr; wr_sel_i = sel; wr_data_i = data;
    ext_i = ext; tick_i = tick; clr_req_i = clr;
    @(negedge clk_i);
    wr_en_i = 1'b0; clr_req_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    rd_check("R1 count", 2'd2, 16'h0);
    rd_check("R1 preload", 2'd0, 16'h0);
    rd_check("R1 ctrl", 2'd1, 16'h0);
    check("R1 req", {15'b0, req_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, 2'd1, {12'b0, VECS[i].ctl}, VECS[i].ext, VECS[i].tick, 1'b0);
      rd_check($sformatf("R%0d vec %0d", VECS[i].req, i), 2'd2, VECS[i].exp);
    end
    // R6 run bit cleared by trailing edge, R10 ctrl readback
    rd_check("R6 run cleared", 2'd1, 16'h0007);

    // R9 preload write while stopped loads count
    step(1'b1, 2'd0, 16'hFFFE, 1'b0, 1'b0, 1'b0);
    rd_check("R9 stopped load", 2'd2, 16'hFFFE);
    rd_check("R10 preload read", 2'd0, 16'hFFFE);
    step(1'b1, 2'd1, 16'h000A, 1'b0, 1'b0, 1'b0);
    rd_check("R10 ctrl read", 2'd1, 16'h000A);
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0);
    rd_check("R4 tick to max", 2'd2, 16'hFFFF);
    check("R7 no req yet", {15'b0, req_o}, 16'h0);
    // R7 wrap reloads preload and sets request
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0);
    rd_check("R7 reload", 2'd2, 16'hFFFE);
    check("R7 req set", {15'b0, req_o}, 16'h1);
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b0);
    rd_check("R8 req held", 2'd3, 16'h1);
    // R9 preload write while running leaves count
    step(1'b1, 2'd0, 16'h0005, 1'b0, 1'b0, 1'b0);
    rd_check("R9 running no load", 2'd2, 16'hFFFE);
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0);
    rd_check("R9 new preload at wrap", 2'd2, 16'h0005);
    // R8 clear
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R8 cleared", {15'b0, req_o}, 16'h0);
    // R8 overflow and clear together: set wins
    step(1'b1, 2'd1, 16'h0002, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    rd_check("R9 load max", 2'd2, 16'hFFFF);
    step(1'b1, 2'd1, 16'h000A, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b1);
    check("R8 set wins", {15'b0, req_o}, 16'h1);
    rd_check("R7 reload max", 2'd2, 16'hFFFF);

    done = 1'b1;
    finish_run();
  end
endmodule